// File: doc/BRIEF.md
# Indirect-Addressed Special Register File

This block is the data-memory front end of a small 8-bit controller core. It takes one read access and one write access per cycle from the core, decodes each address, and sends it either to a few registers held inside the block or on to an external general-purpose RAM array. Two addresses hold no storage of their own. Each one is a window that forwards the access to the location named by its own 8-bit pointer register. The pointed-to location can be anywhere in the data address space: a RAM byte, the accumulator, the status register or a pointer.

The status register holds four arithmetic flags and two power flags. The core and the ALU can write the arithmetic flags. The power flags change only on side-band events: power-on, watchdog clear, halt entry and watchdog expiry. The accumulator and status contents are also brought out directly for the core's datapath.

Top module: `sfr_front`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, both pointers and the whole status register to 00H.
- R2: A read or write at address 00H is forwarded to the address held in pointer 0 (address 01H). An access at 02H is forwarded to the address held in pointer 1 (address 03H). The forwarded address is decoded in the same way as a direct one, so it can reach the RAM, the accumulator, the status register or a pointer. Indirect read data appears in the same cycle.
- R3: If a forwarded address is itself 00H or 02H, a read returns 00H. A write changes no register and raises no RAM write strobe.
- R4: Pointer 0 (01H), pointer 1 (03H) and the accumulator (05H) are 8-bit read/write registers. The accumulator value is also driven on `acc_value`.
- R5: Every address other than 00H, 01H, 02H, 03H, 05H and 0AH goes to the RAM port. A read returns `ram_rd_data` combinationally through `ram_rd_addr`. A write raises `ram_wr_en` in the same cycle. When `rd_en` is low, `rd_data` is 00H. When `wr_en` is low, `ram_wr_en` is low.
- R6: The status register sits at 0AH with this layout: bit0 carry, bit1 half-carry, bit2 zero, bit3 overflow, bit4 sleep flag, bit5 expiry flag. Bits 7:6 always read 0. It is also driven on `status_value`.
- R7: A data write to 0AH, whether direct or indirect, loads only bits 3:0. The sleep and expiry flags keep their values.
- R8: `alu_flag_we` loads bits 3:0 from `alu_flags`, where bit0 is carry and bit3 is overflow. If a data write to the status register happens in the same cycle, the data write wins.
- R9: The power flags are set by side-band events in priority order. `power_on` clears both flags. Otherwise `wdog_clear` clears both. Otherwise `halt_enter` sets the sleep flag and clears the expiry flag. Otherwise `wdog_expire` sets the expiry flag. With no event, both flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read access valid |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write access valid |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| ram_rd_addr | output | 8 | RAM read address (resolved) |
| ram_rd_data | input | 8 | RAM read data |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | 8 | RAM write address (resolved) |
| ram_wr_data | output | 8 | RAM write data |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | ALU flags {overflow, zero, half-carry, carry} |
| power_on | input | 1 | Power-on event |
| wdog_clear | input | 1 | Watchdog clear event |
| halt_enter | input | 1 | Halt entry event |
| wdog_expire | input | 1 | Watchdog expiry event |
| acc_value | output | 8 | Accumulator contents |
| status_value | output | 8 | Status register contents |

## Verification
A pointer that holds the wrong value shows up on the very next indirect access. In that same cycle, `ram_rd_addr` or `ram_wr_addr` points at the wrong byte, or the wrong register's contents appear on `rd_data`. A power flag that a data write has wrongly changed is visible on `status_value` one clock after that write. A wrong event priority shows up one clock after two events arrive together. Self-reference errors show up in the same cycle, either as nonzero read data or as a RAM write strobe.

// File: rtl/sfr_pkg.sv
// Shared constants and types for the special register front end.
// Assumes an 8-bit data path in which the address width equals the data width.
package sfr_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = DATA_W;
    localparam int unsigned ARITH_W = 4;

    localparam logic [ADDR_W-1:0] A_WIN0   = 8'h00;
    localparam logic [ADDR_W-1:0] A_PTR0   = 8'h01;
    localparam logic [ADDR_W-1:0] A_WIN1   = 8'h02;
    localparam logic [ADDR_W-1:0] A_PTR1   = 8'h03;
    localparam logic [ADDR_W-1:0] A_ACC    = 8'h05;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h0A;

    localparam int unsigned B_SLEEP  = 4;
    localparam int unsigned B_EXPIRE = 5;

    typedef enum logic [2:0] {
        TGT_RAM,
        TGT_PTR0,
        TGT_PTR1,
        TGT_ACC,
        TGT_STATUS,
        TGT_NULL
    } target_e;
endpackage

// File: rtl/sfr_addr_resolve.sv
// Resolves one core address to an effective address and a target class.
// A window address is replaced by its pointer; an effective address that
// lands back on a window is classified as a null access.
module sfr_addr_resolve
    import sfr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr0,
    input  logic [ADDR_W-1:0] ptr1,
    output logic [ADDR_W-1:0] eff_addr,
    output target_e           target
);
    // Substitute the pointer for a window address.
    always_comb begin
        if (addr == A_WIN0)      eff_addr = ptr0;
        else if (addr == A_WIN1) eff_addr = ptr1;
        else                     eff_addr = addr;
    end

    // Classify the effective address.
    always_comb begin
        case (eff_addr)
            A_WIN0, A_WIN1: target = TGT_NULL;
            A_PTR0:         target = TGT_PTR0;
            A_PTR1:         target = TGT_PTR1;
            A_ACC:          target = TGT_ACC;
            A_STATUS:       target = TGT_STATUS;
            default:        target = TGT_RAM;
        endcase
    end
endmodule

// File: rtl/sfr_status.sv
// Status register: arithmetic flags in bits 3:0, sleep flag in bit 4 and
// expiry flag in bit 5. Bits 7:6 are zero. A data write wins over an ALU
// update. The power flags follow only the side-band events.
module sfr_status
    import sfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_we,
    input  logic [ARITH_W-1:0] data_flags,
    input  logic               alu_we,
    input  logic [ARITH_W-1:0] alu_flags,
    input  logic               power_on,
    input  logic               wdog_clear,
    input  logic               halt_enter,
    input  logic               wdog_expire,
    output logic [DATA_W-1:0]  status
);
    logic [ARITH_W-1:0] arith_q;
    logic               sleep_q;
    logic               expire_q;

    // Arithmetic flags: a data write has priority over an ALU update.
    always_ff @(posedge clk) begin
        if (!rst_n)       arith_q <= '0;
        else if (data_we) arith_q <= data_flags;
        else if (alu_we)  arith_q <= alu_flags;
    end

    // Power flags: prioritised side-band events only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q  <= 1'b0;
            expire_q <= 1'b0;
        end else if (power_on || wdog_clear) begin
            sleep_q  <= 1'b0;
            expire_q <= 1'b0;
        end else if (halt_enter) begin
            sleep_q  <= 1'b1;
            expire_q <= 1'b0;
        end else if (wdog_expire) begin
            expire_q <= 1'b1;
        end
    end

    // Pack the register image.
    always_comb begin
        status = '0;
        status[ARITH_W-1:0] = arith_q;
        status[B_SLEEP]     = sleep_q;
        status[B_EXPIRE]    = expire_q;
    end

    AST_DATA_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> status[ARITH_W-1:0] == $past(data_flags)); // R8
    AST_POWER_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_on || wdog_clear || halt_enter || wdog_expire)
        |=> $stable(status[B_EXPIRE:B_SLEEP])); // R7
    AST_HALT_SETS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_enter && !power_on && !wdog_clear)
        |=> (status[B_SLEEP] && !status[B_EXPIRE])); // R9
    AST_POWER_ON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        power_on |=> status[B_EXPIRE:B_SLEEP] == 2'b00); // R9
endmodule

// File: rtl/sfr_front.sv
// Data-memory front end: decodes one read and one write access per cycle,
// forwards the two window addresses through their pointers, holds the
// accumulator and pointers, and passes all other addresses to the RAM port.
// Assumes the RAM array has a combinational read and a clocked write.
module sfr_front
    import sfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [ADDR_W-1:0]   ram_rd_addr,
    input  logic [DATA_W-1:0]   ram_rd_data,
    output logic                ram_wr_en,
    output logic [ADDR_W-1:0]   ram_wr_addr,
    output logic [DATA_W-1:0]   ram_wr_data,
    input  logic                alu_flag_we,
    input  logic [ARITH_W-1:0]  alu_flags,
    input  logic                power_on,
    input  logic                wdog_clear,
    input  logic                halt_enter,
    input  logic                wdog_expire,
    output logic [DATA_W-1:0]   acc_value,
    output logic [DATA_W-1:0]   status_value
);
    localparam int unsigned N_PORTS = 2;
    localparam int unsigned P_RD = 0;
    localparam int unsigned P_WR = 1;

    logic [DATA_W-1:0] acc_q, ptr0_q, ptr1_q;
    logic [ADDR_W-1:0] port_addr [N_PORTS];
    logic [ADDR_W-1:0] port_eff  [N_PORTS];
    target_e           port_tgt  [N_PORTS];
    logic              wr_ptr0, wr_ptr1, wr_acc, wr_status;

    assign port_addr[P_RD] = rd_addr;
    assign port_addr[P_WR] = wr_addr;

    // One resolver per access port.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_res
        sfr_addr_resolve u_res (
            .addr     (port_addr[p]),
            .ptr0     (ptr0_q),
            .ptr1     (ptr1_q),
            .eff_addr (port_eff[p]),
            .target   (port_tgt[p])
        );
    end

    // Write strobes per internal target.
    always_comb begin
        wr_ptr0   = wr_en && (port_tgt[P_WR] == TGT_PTR0);
        wr_ptr1   = wr_en && (port_tgt[P_WR] == TGT_PTR1);
        wr_acc    = wr_en && (port_tgt[P_WR] == TGT_ACC);
        wr_status = wr_en && (port_tgt[P_WR] == TGT_STATUS);
    end

    // Pointer and accumulator storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr0_q <= '0;
            ptr1_q <= '0;
            acc_q  <= '0;
        end else begin
            if (wr_ptr0) ptr0_q <= wr_data;
            if (wr_ptr1) ptr1_q <= wr_data;
            if (wr_acc)  acc_q  <= wr_data;
        end
    end

    sfr_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_we     (wr_status),
        .data_flags  (wr_data[ARITH_W-1:0]),
        .alu_we      (alu_flag_we),
        .alu_flags   (alu_flags),
        .power_on    (power_on),
        .wdog_clear  (wdog_clear),
        .halt_enter  (halt_enter),
        .wdog_expire (wdog_expire),
        .status      (status_value)
    );

    // RAM port driving.
    always_comb begin
        ram_rd_addr = port_eff[P_RD];
        ram_wr_addr = port_eff[P_WR];
        ram_wr_data = wr_data;
        ram_wr_en   = wr_en && (port_tgt[P_WR] == TGT_RAM);
    end

    // Read data selection.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (port_tgt[P_RD])
                TGT_PTR0:   rd_data = ptr0_q;
                TGT_PTR1:   rd_data = ptr1_q;
                TGT_ACC:    rd_data = acc_q;
                TGT_STATUS: rd_data = status_value;
                TGT_RAM:    rd_data = ram_rd_data;
                default:    rd_data = '0;
            endcase
        end
    end

    assign acc_value = acc_q;

    AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_WIN0 && (ptr0_q == A_WIN0 || ptr0_q == A_WIN1))
        |-> rd_data == '0); // R3
    AST_NULL_NO_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_WIN1 && (ptr1_q == A_WIN0 || ptr1_q == A_WIN1))
        |-> !ram_wr_en); // R3
    AST_PTR0_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PTR0) |=> ptr0_q == $past(wr_data)); // R4
    AST_RAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !ram_wr_en); // R5
endmodule

// File: tb/test_sfr_front.sv
// Directed bench for sfr_front: one task per scenario, each checking itself.
module test_sfr_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    logic [7:0] rd_data, ram_rd_addr, ram_rd_data, ram_wr_addr, ram_wr_data;
    logic       ram_wr_en;
    logic       alu_flag_we = 1'b0;
    logic [3:0] alu_flags = '0;
    logic       power_on = 1'b0, wdog_clear = 1'b0, halt_enter = 1'b0, wdog_expire = 1'b0;
    logic [7:0] acc_value, status_value;
    logic [7:0] mem [256];
    logic       seen_we;
    int         checks = 0, errors = 0;

    always #10 clk = ~clk;

    sfr_front i_sfr_front (
        .clk, .rst_n, .rd_en, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data,
        .ram_rd_addr, .ram_rd_data, .ram_wr_en, .ram_wr_addr, .ram_wr_data,
        .alu_flag_we, .alu_flags, .power_on, .wdog_clear, .halt_enter,
        .wdog_expire, .acc_value, .status_value
    );

    // RAM array model
    assign ram_rd_data = mem[ram_rd_addr];
    always @(posedge clk) if (ram_wr_en) mem[ram_wr_addr] <= ram_wr_data;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 seen_we = ram_wr_en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 check(req, rd_data, exp);
        rd_en = 1'b0;
    endtask

    task automatic events(input logic pu, input logic wc, input logic ht, input logic ex);
        @(negedge clk);
        power_on = pu; wdog_clear = wc; halt_enter = ht; wdog_expire = ex;
        @(negedge clk);
        power_on = 1'b0; wdog_clear = 1'b0; halt_enter = 1'b0; wdog_expire = 1'b0;
    endtask

    task automatic t_reset();
        read_check("R1 ptr0", 8'h01, 8'h00);
        read_check("R1 ptr1", 8'h03, 8'h00);
        read_check("R1 acc", 8'h05, 8'h00);
        read_check("R1 status", 8'h0A, 8'h00);
        check("R1 ram_wr_en", {7'd0, ram_wr_en}, 8'h00);
    endtask

    task automatic t_registers();
        do_write(8'h01, 8'h40);
        read_check("R4 ptr0", 8'h01, 8'h40);
        do_write(8'h03, 8'h41);
        read_check("R4 ptr1", 8'h03, 8'h41);
        do_write(8'h05, 8'h5A);
        read_check("R4 acc", 8'h05, 8'h5A);
        check("R4 acc_value", acc_value, 8'h5A);
    endtask

    task automatic t_direct_ram();
        read_check("R5 initial ram", 8'h30, 8'h30 ^ 8'hA5);
        do_write(8'h20, 8'h33);
        check("R5 ram strobe", {7'd0, seen_we}, 8'h01);
        check("R5 ram content", mem[8'h20], 8'h33);
        read_check("R5 ram read", 8'h20, 8'h33);
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 8'h20;
        #1 check("R5 idle read", rd_data, 8'h00);
        do_write(8'h05, 8'h11);
        check("R5 no strobe for acc", {7'd0, seen_we}, 8'h00);
    endtask

    task automatic t_indirect();
        do_write(8'h00, 8'h77);
        check("R2 win0 ram", mem[8'h40], 8'h77);
        read_check("R2 win0 read", 8'h00, 8'h77);
        do_write(8'h02, 8'h88);
        read_check("R2 win1 direct", 8'h41, 8'h88);
        do_write(8'h01, 8'h05);
        do_write(8'h00, 8'h99);
        check("R2 win0 to acc", acc_value, 8'h99);
        read_check("R2 win0 read acc", 8'h00, 8'h99);
    endtask

    task automatic t_null();
        do_write(8'h01, 8'h00);
        do_write(8'h00, 8'h55);
        check("R3 self write strobe", {7'd0, seen_we}, 8'h00);
        read_check("R3 self read", 8'h00, 8'h00);
        read_check("R3 ptr0 kept", 8'h01, 8'h00);
        check("R3 acc kept", acc_value, 8'h99);
        do_write(8'h01, 8'h02);
        read_check("R3 cross read", 8'h00, 8'h00);
        do_write(8'h03, 8'h02);
        do_write(8'h02, 8'h66);
        check("R3 win1 strobe", {7'd0, seen_we}, 8'h00);
        read_check("R3 win1 read", 8'h02, 8'h00);
        read_check("R3 ptr1 kept", 8'h03, 8'h02);
    endtask

    task automatic t_status();
        do_write(8'h0A, 8'hFF);
        read_check("R6 R7 write ff", 8'h0A, 8'h0F);
        events(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 halt", status_value, 8'h1F);
        do_write(8'h0A, 8'h00);
        check("R7 sleep kept", status_value, 8'h10);
        events(1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 expire", status_value, 8'h30);
        do_write(8'h0A, 8'hF5);
        check("R7 R6 write f5", status_value, 8'h35);
        events(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 wdog clear", status_value, 8'h05);
        events(1'b0, 1'b0, 1'b1, 1'b1);
        check("R9 halt over expire", status_value, 8'h15);
        events(1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 expire after halt", status_value, 8'h35);
        events(1'b1, 1'b0, 1'b1, 1'b1);
        check("R9 power on", status_value, 8'h05);
        events(1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 clear over halt", status_value, 8'h05);
    endtask

    task automatic t_alu();
        @(negedge clk);
        alu_flag_we = 1'b1; alu_flags = 4'b1010;
        @(negedge clk);
        alu_flag_we = 1'b0;
        check("R8 alu load", status_value, 8'h0A);
        events(1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        alu_flag_we = 1'b1; alu_flags = 4'b1100;
        wr_en = 1'b1; wr_addr = 8'h0A; wr_data = 8'h03;
        @(negedge clk);
        alu_flag_we = 1'b0; wr_en = 1'b0;
        check("R8 write wins", status_value, 8'h13);
        do_write(8'h03, 8'h0A);
        do_write(8'h02, 8'hFC);
        check("R7 indirect status", status_value, 8'h1C);
        read_check("R2 R6 indirect status read", 8'h02, 8'h1C);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_registers();
        t_direct_ram();
        do_write(8'h01, 8'h40);
        t_indirect();
        t_null();
        t_status();
        t_alu();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule